// File: doc/BRIEF.md
# OTG Timeout Timer and Power-Up Interrupt Gate

This block provides two timing services for a USB OTG companion device. The first is a one-shot timeout counter controlled through a single 32-bit register. The top bit of that register arms the counter. The low 27 bits give the delay in device-clock cycles. When the delay runs out, the block emits a one-cycle timeout pulse toward the interrupt logic and clears the register. Rewriting the register either restarts the count or cancels it.

The second service qualifies interrupt delivery after power-up. When the power input goes from off to on, the `intr_ok` qualifier drops at once and stays low for a fixed settling window of `HOLD_CYCLES` clocks. By default this is 30,000,000 cycles, which is half a second at 60 MHz. The qualifier is then released, provided power is still on. Removing power only returns the gate to its off state and leaves `intr_ok` as it was.

Each function is a small state machine. The timer has the states `TMR_IDLE` and `TMR_ARMED`. Its transitions are:
- arm: a write with the enable bit set moves IDLE to ARMED.
- restart: a write with the enable bit set while ARMED stays in ARMED.
- cancel: a write with the enable bit clear moves ARMED to IDLE.
- expire: the count runs out with no write in that cycle, moving ARMED to IDLE.

The gate has the states `GATE_OFF`, `GATE_SETTLE` and `GATE_ON`. Its transitions are:
- power-up: power is high in OFF, moving to SETTLE.
- release: the window ends with power still high, moving SETTLE to ON.
- abort: power is low in SETTLE, moving to OFF.
- power-down: power is low in ON, moving to OFF.

Both machines share one down-counter design.

Top module: `otg_tmr_pwr_gate`

## Requirements
- R1: While reset is asserted and right after it, `tmr_rd_data` is 0, `timeout_pulse` is 0, `intr_ok` is 0 and the gate is in its off state. A timeout that was armed before reset never fires.
- R2: A write (`tmr_wr_en` high for one cycle) stores all 32 bits of `tmr_wr_data`. `tmr_rd_data` returns that value from the next cycle until expiry or the next write.
- R3: A write with bit 31 set arms the timer with the count in bits [26:0]; bits [30:27] do not affect the count. `timeout_pulse` is high for exactly one cycle, N cycles after the write edge, where N is the count.
- R4: A count of 0 behaves like a count of 1.
- R5: In the cycle `timeout_pulse` is high, `tmr_rd_data` already reads 0, and it stays 0 until the next write.
- R6: A write with bit 31 clear cancels any pending timeout, and no pulse follows.
- R7: A write with bit 31 set while the timer is armed discards the old count and restarts from the new one. A write takes priority over an expiry in the same cycle.
- R8: When power is sampled high in the off state, `intr_ok` reads 0 in the next cycle. It becomes 1 exactly `HOLD_CYCLES` cycles after the sampling edge.
- R9: Power going low during the settling window aborts it, and `intr_ok` stays 0. A later power-up starts a full new window.
- R10: Power going low leaves `intr_ok` unchanged.
- R11: Power held high after release has no further effect, and `intr_ok` stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Device clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tmr_wr_en | input | 1 | Write strobe for the timer register |
| tmr_wr_data | input | 32 | Timer write value: bit 31 enable, bits [26:0] count |
| tmr_rd_data | output | 32 | Timer register read value |
| timeout_pulse | output | 1 | One-cycle timeout event to the interrupt logic |
| pwr_in | input | 1 | Power-on level of the device |
| intr_ok | output | 1 | Interrupt delivery qualifier |

## Verification
The hardest state to reach from the ports is a power drop in the middle of the settling window, followed by a new power-up. The bench shortens the window through `HOLD_CYCLES`. It first releases the gate and drops power, so that `intr_ok` is known to be 1 and must be cleared again. It then raises power, drops it partway through the window, waits twice the window length, and raises it once more to time a complete fresh window. On the timer side, a restart is forced by rewriting the register a few cycles after arming. The bench then checks that the pulse follows the second count and not the first.

// File: rtl/otg_tmr_pkg.sv
package otg_tmr_pkg;

    localparam int unsigned TMR_REG_W  = 32;
    localparam int unsigned TMR_CNT_W  = 27;
    localparam int unsigned TMR_EN_BIT = 31;

    typedef enum logic [0:0] {
        TMR_IDLE  = 1'b0,
        TMR_ARMED = 1'b1
    } tmr_state_e;

    typedef enum logic [1:0] {
        GATE_OFF    = 2'd0,
        GATE_SETTLE = 2'd1,
        GATE_ON     = 2'd2
    } gate_state_e;

endpackage

// File: rtl/otg_down_counter.sv
module otg_down_counter #(
    parameter int unsigned W = 27
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         dec,
    output logic         last
);

    localparam logic [W-1:0] ONE = W'(1);

    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (dec && (cnt_q != '0)) begin
            cnt_q <= cnt_q - ONE;
        end
    end

    // Final cycle of a countdown; a load of zero is treated like one
    assign last = (cnt_q <= ONE);

endmodule

// File: rtl/otg_oneshot_timer.sv
module otg_oneshot_timer
    import otg_tmr_pkg::*;
#(
    parameter int unsigned REG_W  = TMR_REG_W,
    parameter int unsigned CNT_W  = TMR_CNT_W,
    parameter int unsigned EN_BIT = TMR_EN_BIT
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    output logic [REG_W-1:0] rd_data,
    output logic             timeout_pulse
);

    tmr_state_e       state_q, state_d;
    logic             wr_arm;
    logic [CNT_W-1:0] wr_cnt;
    logic             cnt_last;
    logic             expire;
    logic [REG_W-1:0] value_q;
    logic             pulse_q;

    assign wr_arm = wr_data[EN_BIT];
    assign wr_cnt = wr_data[CNT_W-1:0];
    // A write in the same cycle wins over an expiry
    assign expire = (state_q == TMR_ARMED) && cnt_last && !wr_en;

    otg_down_counter #(.W(CNT_W)) cnt_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (wr_en && wr_arm),
        .load_val (wr_cnt),
        .dec      (state_q == TMR_ARMED),
        .last     (cnt_last)
    );

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= TMR_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TMR_IDLE: begin
                if (wr_en && wr_arm) begin
                    state_d = TMR_ARMED;            // arm
                end
            end
            TMR_ARMED: begin
                if (wr_en) begin
                    state_d = wr_arm ? TMR_ARMED    // restart
                                     : TMR_IDLE;    // cancel
                end else if (cnt_last) begin
                    state_d = TMR_IDLE;             // expire
                end
            end
            default: state_d = TMR_IDLE;
        endcase
    end

    // Outputs: register value and timeout event
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            value_q <= '0;
            pulse_q <= 1'b0;
        end else begin
            pulse_q <= expire;
            if (wr_en) begin
                value_q <= wr_data;
            end else if (expire) begin
                value_q <= '0;
            end
        end
    end

    assign rd_data       = value_q;
    assign timeout_pulse = pulse_q;

endmodule

// File: rtl/otg_pwr_holdoff.sv
module otg_pwr_holdoff
    import otg_tmr_pkg::*;
#(
    parameter int unsigned HOLD_CYCLES = 30_000_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pwr_in,
    output logic intr_ok
);

    localparam int unsigned HOLD_W = $clog2(HOLD_CYCLES + 1);
    localparam logic [HOLD_W-1:0] HOLD_VAL = HOLD_W'(HOLD_CYCLES);

    gate_state_e state_q, state_d;
    logic        cnt_last;
    logic        power_up;
    logic        ok_q;

    assign power_up = (state_q == GATE_OFF) && pwr_in;

    otg_down_counter #(.W(HOLD_W)) cnt_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (power_up),
        .load_val (HOLD_VAL),
        .dec      (state_q == GATE_SETTLE),
        .last     (cnt_last)
    );

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= GATE_OFF;
        end else begin
            state_q <= state_d;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            GATE_OFF: begin
                if (pwr_in) begin
                    state_d = GATE_SETTLE;          // power-up
                end
            end
            GATE_SETTLE: begin
                if (!pwr_in) begin
                    state_d = GATE_OFF;             // abort
                end else if (cnt_last) begin
                    state_d = GATE_ON;              // release
                end
            end
            GATE_ON: begin
                if (!pwr_in) begin
                    state_d = GATE_OFF;             // power-down
                end
            end
            default: state_d = GATE_OFF;
        endcase
    end

    // Output register: drops on power-up, rises on release, holds otherwise
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ok_q <= 1'b0;
        end else if (power_up) begin
            ok_q <= 1'b0;
        end else if ((state_q == GATE_SETTLE) && pwr_in && cnt_last) begin
            ok_q <= 1'b1;
        end
    end

    assign intr_ok = ok_q;

endmodule

// File: rtl/otg_tmr_pwr_gate.sv
module otg_tmr_pwr_gate #(
    parameter int unsigned REG_W       = 32,
    parameter int unsigned CNT_W       = 27,
    parameter int unsigned EN_BIT      = 31,
    parameter int unsigned HOLD_CYCLES = 30_000_000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tmr_wr_en,
    input  logic [REG_W-1:0] tmr_wr_data,
    output logic [REG_W-1:0] tmr_rd_data,
    output logic             timeout_pulse,
    input  logic             pwr_in,
    output logic             intr_ok
);

    otg_oneshot_timer #(
        .REG_W  (REG_W),
        .CNT_W  (CNT_W),
        .EN_BIT (EN_BIT)
    ) tmr_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .wr_en         (tmr_wr_en),
        .wr_data       (tmr_wr_data),
        .rd_data       (tmr_rd_data),
        .timeout_pulse (timeout_pulse)
    );

    otg_pwr_holdoff #(
        .HOLD_CYCLES (HOLD_CYCLES)
    ) gate_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .pwr_in  (pwr_in),
        .intr_ok (intr_ok)
    );

endmodule

// File: rtl/otg_tmr_pwr_gate_chk.sv
module otg_tmr_pwr_gate_chk #(
    parameter int unsigned REG_W  = 32,
    parameter int unsigned EN_BIT = 31
) (
    input logic             clk,
    input logic             rst_n,
    input logic             tmr_wr_en,
    input logic [REG_W-1:0] tmr_wr_data,
    input logic [REG_W-1:0] tmr_rd_data,
    input logic             timeout_pulse,
    input logic             pwr_in,
    input logic             intr_ok
);

    // R2
    wr_readback_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tmr_wr_en |=> (tmr_rd_data == $past(tmr_wr_data)));

    // R3
    pulse_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        timeout_pulse |=> !timeout_pulse);

    // R5
    expiry_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        timeout_pulse |-> (tmr_rd_data == '0));

    // R6
    cancel_no_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tmr_wr_en && !tmr_wr_data[EN_BIT]) |=> !timeout_pulse);

    // R8
    powerup_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(pwr_in) && pwr_in) |=> !intr_ok);

    // R9
    release_needs_power_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(intr_ok) |-> $past(pwr_in));

    // R10
    poweroff_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pwr_in |=> $stable(intr_ok));

endmodule

bind otg_tmr_pwr_gate otg_tmr_pwr_gate_chk #(
    .REG_W  (REG_W),
    .EN_BIT (EN_BIT)
) chk_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .tmr_wr_en     (tmr_wr_en),
    .tmr_wr_data   (tmr_wr_data),
    .tmr_rd_data   (tmr_rd_data),
    .timeout_pulse (timeout_pulse),
    .pwr_in        (pwr_in),
    .intr_ok       (intr_ok)
);

// File: tb/otg_tmr_pwr_gate_tb_top.sv
`timescale 1ns/1ps
module otg_tmr_pwr_gate_tb_top;

    localparam int unsigned HOLD = 20;
    localparam int unsigned NVEC = 6;

    // Stimulus word and the cycle of the expected pulse (0 = none)
    localparam logic [31:0] VEC_DATA [NVEC] = '{
        32'h8000_0001, 32'h8000_0002, 32'h8000_0006,
        32'h8000_0000, 32'h0000_0007, 32'hF800_0004
    };
    localparam int VEC_EXP [NVEC] = '{1, 2, 6, 1, 0, 4};
    localparam string VEC_REQ [NVEC] = '{"R3", "R3", "R3", "R4", "R6", "R3"};

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tmr_wr_en = 1'b0;
    logic [31:0] tmr_wr_data = '0;
    logic [31:0] tmr_rd_data;
    logic        timeout_pulse;
    logic        pwr_in = 1'b0;
    logic        intr_ok;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    otg_tmr_pwr_gate #(.HOLD_CYCLES(HOLD)) dut_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .tmr_wr_en     (tmr_wr_en),
        .tmr_wr_data   (tmr_wr_data),
        .tmr_rd_data   (tmr_rd_data),
        .timeout_pulse (timeout_pulse),
        .pwr_in        (pwr_in),
        .intr_ok       (intr_ok)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Called just after a negedge; returns just after the next negedge
    task automatic write_reg(input logic [31:0] d);
        tmr_wr_en   = 1'b1;
        tmr_wr_data = d;
        @(negedge clk);
        tmr_wr_en   = 1'b0;
        tmr_wr_data = '0;
    endtask

    // Observe the timer for ncyc cycles after a write
    task automatic watch_timer(input int ncyc, input logic [31:0] hold_val,
                               output int first, output int npulse, output bit rd_ok);
        first = 0; npulse = 0; rd_ok = 1'b1;
        for (int i = 1; i <= ncyc; i++) begin
            @(negedge clk);
            if (timeout_pulse) begin
                npulse++;
                if (first == 0) first = i;
            end
            if (first == 0 && tmr_rd_data != hold_val) rd_ok = 1'b0;
            if (first != 0 && tmr_rd_data != '0) rd_ok = 1'b0;
        end
    endtask

    // Cycle in which intr_ok first reads 1 after a power edge (0 = never)
    task automatic watch_ok(input int ncyc, output int first);
        first = 0;
        for (int i = 1; i <= ncyc; i++) begin
            @(negedge clk);
            if (intr_ok && first == 0) first = i;
        end
    endtask

    initial begin
        int first, npulse, exp_first;
        bit rd_ok;

        // R1: reset state
        repeat (3) @(negedge clk);
        check(tmr_rd_data == '0, "R1", "rd_data in reset", tmr_rd_data, 0);
        check(!timeout_pulse && !intr_ok, "R1", "pulse/intr_ok in reset",
              {30'd0, timeout_pulse, intr_ok}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(tmr_rd_data == '0 && !intr_ok, "R1", "state after reset",
              tmr_rd_data, 0);

        // Vector table: R2..R6
        for (int v = 0; v < NVEC; v++) begin
            write_reg(VEC_DATA[v]);
            check(tmr_rd_data == VEC_DATA[v], "R2", "readback after write",
                  tmr_rd_data, VEC_DATA[v]);
            watch_timer(10, VEC_DATA[v], first, npulse, rd_ok);
            check(first == VEC_EXP[v], VEC_REQ[v], "pulse cycle", first, VEC_EXP[v]);
            check(npulse == (VEC_EXP[v] != 0 ? 1 : 0), VEC_REQ[v], "pulse count",
                  npulse, (VEC_EXP[v] != 0 ? 1 : 0));
            check(rd_ok, "R5", "readback before/after expiry", tmr_rd_data,
                  (VEC_EXP[v] != 0) ? 32'h0 : VEC_DATA[v]);
        end

        // R6: cancel a pending timeout
        write_reg(32'h8000_000A);
        repeat (3) @(negedge clk);
        write_reg(32'h0000_0005);
        watch_timer(15, 32'h0000_0005, first, npulse, rd_ok);
        check(npulse == 0, "R6", "no pulse after cancel", npulse, 0);
        check(tmr_rd_data == 32'h5, "R6", "value after cancel", tmr_rd_data, 32'h5);

        // R7: restart while armed
        write_reg(32'h8000_000A);
        watch_timer(4, 32'h8000_000A, first, npulse, rd_ok);
        check(npulse == 0, "R7", "no pulse before rewrite", npulse, 0);
        write_reg(32'h8000_0003);
        watch_timer(12, 32'h8000_0003, first, npulse, rd_ok);
        check(first == 3, "R7", "pulse follows new count", first, 3);
        check(npulse == 1, "R7", "single pulse after restart", npulse, 1);

        // R8: hold-off length
        pwr_in = 1'b1;
        exp_first = HOLD + 1;
        watch_ok(HOLD + 5, first);
        check(first == exp_first, "R8", "release cycle", first, exp_first);

        // R10: power off keeps intr_ok
        pwr_in = 1'b0;
        repeat (5) @(negedge clk);
        check(intr_ok == 1'b1, "R10", "intr_ok after power off", intr_ok, 1);

        // R8: new power-up clears the qualifier at once
        pwr_in = 1'b1;
        @(negedge clk);
        check(intr_ok == 1'b0, "R8", "clear after power-up", intr_ok, 0);
        watch_ok(HOLD + 5, first);
        check(first == HOLD, "R8", "second release cycle", first, HOLD);

        // R11: power held high changes nothing
        first = 1;
        for (int i = 0; i < HOLD + 10; i++) begin
            @(negedge clk);
            if (!intr_ok) first = 0;
        end
        check(first == 1, "R11", "intr_ok stays set", first, 1);

        // R9: abort in the settling window, then a full fresh window
        pwr_in = 1'b0;
        @(negedge clk);
        pwr_in = 1'b1;
        repeat (5) @(negedge clk);
        pwr_in = 1'b0;
        watch_ok(2 * HOLD, first);
        check(first == 0, "R9", "no release after abort", first, 0);
        pwr_in = 1'b1;
        watch_ok(HOLD + 5, first);
        check(first == HOLD + 1, "R9", "full window after abort", first, HOLD + 1);

        // R1: reset while armed
        write_reg(32'h8000_0008);
        repeat (2) @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        check(tmr_rd_data == '0 && !intr_ok, "R1", "state after mid-run reset",
              {tmr_rd_data[31:1], intr_ok}, 0);
        pwr_in = 1'b0;
        watch_timer(12, 32'h0, first, npulse, rd_ok);
        check(npulse == 0, "R1", "no pulse after reset", npulse, 0);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #2000000;
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule